// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Write Queue

This block is a direct-mapped data cache with one word per line. It sits between a processor load/store port and a slower next-level memory. Every store is written through: the cache updates its own copy only when the store hits, and it always posts the store into a small in-order queue. The queue empties towards memory in the background, so a store holds up the processor only when the queue is already full. A store that misses does not allocate a line. It clears the valid bit of the line at that index, so the line can never hold a stale value.

A load that hits returns in the same cycle. A load that misses first looks in the posted-write queue. If one or more queued stores target the same word, the most recent of them supplies the data at once, and that word is placed in the cache. Otherwise the processor is stalled while the block fetches the word from memory. The fetched word is installed and then returned. Lines are never dirty, so a load miss never writes anything back to memory.

The processor holds a request, with its address, kind and data, until a cycle in which the stall output is low. The memory side uses a single request/acknowledge port shared between queue drains and line fills.

Top module: `wt_cache`

## Requirements
- R1: After reset every line is invalid, the posted-write queue is empty, `cpu_stall` is low while no request is present, and `mem_req` is low.
- R2: A store completes in the cycle it is presented, without stall, whenever fewer than 4 stores are queued. With 4 stores queued, a store is stalled.
- R3: A store whose word address matches the valid line at its index updates that line, so a later load of the address hits and returns the new value.
- R4: A store that misses clears the valid bit of the line at its index and does not allocate. A following load of the address previously held there misses.
- R5: Queued stores reach memory in program order, one per acknowledged write request. The final memory image equals the last value stored to each address.
- R6: A load miss whose address matches queued stores completes in the same cycle, with no stall, returning the data of the youngest matching store.
- R7: A word forwarded from the queue is installed in the cache, so a later load of that address hits after the queue has drained.
- R8: A load miss with no queue match stalls and raises a memory read request (`mem_we` = 0) for that address. It does not write to memory. The load completes, without stall, in the cycle after the acknowledge, with the fetched word.
- R9: Once raised, `mem_req` stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle `mem_ack` is high.
- R10: A load that hits completes in the cycle it is presented, with no stall. The line index is the low `INDEX_W` bits of the word address and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when the load completes |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_req | output | 1 | Next-level memory request |
| mem_we | output | 1 | 1 = write (queue drain), 0 = read (line fill) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory accepts or completes the request this cycle |
| mem_rdata | input | DATA_W | Read data, sampled with `mem_ack` |

## Verification
The assertions assume that the processor holds a stalled request steady until it completes. The properties on fill requests and on post-fill completion depend on this, because the fill address is taken straight from the held request. The assertions also assume that memory returns read data in the same cycle as its acknowledge. The stimulus meets both assumptions. Each access is driven on the falling edge and is kept unchanged until the stall output is low. Stall probes leave the request asserted, so the following access continues it. The memory model answers every read from its array in the acknowledge cycle.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_WRITE = 2'd1,
    ARB_READ  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/wt_line_store.sv
module wt_line_store #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx,
  output logic               hit_valid,
  output logic [TAG_W-1:0]   hit_tag,
  output logic [DATA_W-1:0]  hit_data,
  input  logic               wr_en,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               inv_en
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en)       valid_d[idx] = 1'b1;
    else if (inv_en) valid_d[idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic line_we;
    assign line_we = wr_en && (idx == INDEX_W'(g));
    always_ff @(posedge clk) begin
      if (line_we) begin
        tag_q[g]  <= wr_tag;
        data_q[g] <= wr_data;
      end
    end
  end

  assign hit_valid = valid_q[idx];
  assign hit_tag   = tag_q[idx];
  assign hit_data  = data_q[idx];
endmodule

// File: rtl/wt_write_buffer.sv
module wt_write_buffer #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_data
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push) tail_d = (tail_q == PTR_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
    if (pop)  head_d = (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (tail_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        addr_q[g] <= push_addr;
        data_q[g] <= push_data;
      end
    end
  end

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    logic [PTR_W-1:0] slot;
    look_hit  = 1'b0;
    look_data = '0;
    slot      = head_q;
    for (int k = 0; k < DEPTH; k++) begin
      if ((CNT_W'(k) < cnt_q) && (addr_q[slot] == look_addr)) begin
        look_hit  = 1'b1;
        look_data = data_q[slot];
      end
      slot = (slot == PTR_W'(DEPTH - 1)) ? '0 : slot + 1'b1;
    end
  end

  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign count     = cnt_q;
endmodule

// File: rtl/wt_mem_arb.sv
module wt_mem_arb
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_need,
  input  logic              wb_empty,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              drain_pop,
  output logic              fill_done
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (fill_need)     state_d = ARB_READ;
        else if (!wb_empty) state_d = ARB_WRITE;
      end
      ARB_WRITE: if (mem_ack) state_d = fill_need ? ARB_READ : ARB_IDLE;
      ARB_READ:  if (mem_ack) state_d = ARB_IDLE;
      default:   state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  assign mem_req   = (state_q != ARB_IDLE);
  assign mem_we    = (state_q == ARB_WRITE);
  assign mem_addr  = (state_q == ARB_READ) ? fill_addr : wb_addr;
  assign mem_wdata = wb_data;
  assign drain_pop = (state_q == ARB_WRITE) && mem_ack;
  assign fill_done = (state_q == ARB_READ) && mem_ack;
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int INDEX_W  = 4,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - INDEX_W;
  localparam int CNT_W = $clog2(WB_DEPTH + 1);

  logic [INDEX_W-1:0] cpu_idx;
  logic [TAG_W-1:0]   cpu_tag;
  logic               ln_valid, lk_hit;
  logic [TAG_W-1:0]   ln_tag;
  logic [DATA_W-1:0]  ln_data;
  logic               wb_full, wb_empty, wb_pop, fwd_hit, fill_done, fill_need;
  logic [CNT_W-1:0]   wb_cnt;
  logic [ADDR_W-1:0]  wb_addr;
  logic [DATA_W-1:0]  wb_data, fwd_data;
  logic               rd_req, wr_go;
  logic               ls_wr_en, ls_inv;
  logic [DATA_W-1:0]  ls_wr_data;

  assign cpu_idx   = cpu_addr[INDEX_W-1:0];
  assign cpu_tag   = cpu_addr[ADDR_W-1:INDEX_W];
  assign lk_hit    = ln_valid && (ln_tag == cpu_tag);
  assign rd_req    = cpu_req && !cpu_we;
  assign wr_go     = cpu_req && cpu_we && !wb_full;
  assign fill_need = rd_req && !lk_hit && !fwd_hit;
  assign cpu_stall = fill_need || (cpu_req && cpu_we && wb_full);
  assign cpu_rdata = lk_hit ? ln_data : fwd_data;

  // Line update selection: fill, forward-install, store hit, store miss.
  always_comb begin
    ls_wr_en   = 1'b0;
    ls_inv     = 1'b0;
    ls_wr_data = cpu_wdata;
    if (fill_done) begin
      ls_wr_en   = 1'b1;
      ls_wr_data = mem_rdata;
    end else if (rd_req && !lk_hit && fwd_hit) begin
      ls_wr_en   = 1'b1;
      ls_wr_data = fwd_data;
    end else if (wr_go && lk_hit) begin
      ls_wr_en   = 1'b1;
    end else if (wr_go) begin
      ls_inv     = 1'b1;
    end
  end

  wt_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .idx(cpu_idx),
    .hit_valid(ln_valid), .hit_tag(ln_tag), .hit_data(ln_data),
    .wr_en(ls_wr_en), .wr_tag(cpu_tag), .wr_data(ls_wr_data), .inv_en(ls_inv)
  );

  wt_write_buffer #(.DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(wr_go), .push_addr(cpu_addr), .push_data(cpu_wdata),
    .pop(wb_pop), .head_addr(wb_addr), .head_data(wb_data),
    .full(wb_full), .empty(wb_empty), .count(wb_cnt),
    .look_addr(cpu_addr), .look_hit(fwd_hit), .look_data(fwd_data)
  );

  wt_mem_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .fill_need(fill_need), .wb_empty(wb_empty),
    .wb_addr(wb_addr), .wb_data(wb_data), .fill_addr(cpu_addr), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .drain_pop(wb_pop), .fill_done(fill_done)
  );
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int WB_DEPTH = 4,
  localparam int CNT_W   = $clog2(WB_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [CNT_W-1:0]  wb_cnt
);
  assert_store_stall_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_stall) |-> (wb_cnt == CNT_W'(WB_DEPTH)));

  assert_queue_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cnt <= CNT_W'(WB_DEPTH));

  assert_drain_needs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (wb_cnt != '0));

  assert_fill_for_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (cpu_req && !cpu_we));

  assert_fill_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> !cpu_stall);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata)));
endmodule

bind wt_cache wt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_stall(cpu_stall),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .wb_cnt(wb_cnt)
);

// File: tb/sim_wt_cache.sv
`timescale 1ns/1ps
module sim_wt_cache;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_stall, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_ack = 1'b0;
  logic          ack_en = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mem_img [1 << AW];
  logic [DW-1:0] ref_img [1 << AW];
  logic [AW+DW-1:0] exp_wr [2048];
  int n_exp = 0, n_seen = 0;
  int seed_dummy;

  always #2.5 clk = ~clk;

  wt_cache #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW), .WB_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] seed_word(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Memory model: same-cycle read data, write on acknowledged write.
  assign mem_rdata = mem_img[mem_addr];
  always @(negedge clk) mem_ack <= ack_en && mem_req && ($urandom % 3 != 0);
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack && mem_we) begin
      mem_img[mem_addr] <= mem_wdata;
      check("R5 drain order", {mem_addr, mem_wdata}, exp_wr[n_seen]);
      n_seen++;
    end
  end

  // Complete one access; returns load data and stalled cycle count.
  task automatic op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    output logic [DW-1:0] rd, output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    waits = 0;
    #2;
    while (cpu_stall && waits < 2000) begin
      waits++;
      @(negedge clk);
      #2;
    end
    rd = cpu_rdata;
    if (we) begin
      ref_img[a] = d;
      exp_wr[n_exp] = {a, d};
      n_exp++;
    end
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  // Present an access and sample stall, leaving it asserted.
  task automatic probe(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic st);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #2 st = cpu_stall;
  endtask

  task automatic drain();
    ack_en = 1'b1;
    repeat (80) @(posedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    int w;
    logic st;
    seed_dummy = $urandom(32'd4242);
    for (int i = 0; i < (1 << AW); i++) begin
      mem_img[i] = seed_word(i);
      ref_img[i] = seed_word(i);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    check("R1 stall idle", {31'd0, cpu_stall}, 32'd0);
    check("R1 mem_req idle", {31'd0, mem_req}, 32'd0);

    // R1/R8: empty cache misses; fill read request issued, no write.
    probe(1'b0, 12'h005, '0, st);
    check("R1 empty cache load stalls", {31'd0, st}, 32'd1);
    @(posedge clk); #2;
    check("R8 fill request kind/addr", {19'd0, mem_req, mem_we, mem_addr},
          {19'd0, 1'b1, 1'b0, 12'h005});
    ack_en = 1'b1;
    op(1'b0, 12'h005, '0, rd, w);
    check("R8 fill data", rd, seed_word(12'h005));
    op(1'b0, 12'h005, '0, rd, w);
    check("R10 load hit no stall", 32'(w), 32'd0);
    check("R10 load hit data", rd, seed_word(12'h005));

    // R2/R3: store hit, no stall, read back from line.
    op(1'b1, 12'h005, 32'hAAAA0001, rd, w);
    check("R2 store no stall", 32'(w), 32'd0);
    drain();
    ack_en = 1'b0;
    op(1'b0, 12'h005, '0, rd, w);
    check("R3 store hit updates line", rd, 32'hAAAA0001);
    check("R3 hit no stall", 32'(w), 32'd0);

    // R4: store miss at same index invalidates, old address then misses.
    op(1'b1, 12'h015, 32'hBBBB0002, rd, w);
    probe(1'b0, 12'h005, '0, st);
    check("R4 invalidated line misses", {31'd0, st}, 32'd1);
    ack_en = 1'b1;
    op(1'b0, 12'h005, '0, rd, w);
    check("R4 refetched value", rd, 32'hAAAA0001);
    drain();

    // R6/R2/R7: youngest forwarding, full queue stall, install of forwarded word.
    ack_en = 1'b0;
    op(1'b1, 12'h027, 32'hC0000001, rd, w);
    op(1'b1, 12'h037, 32'hC0000002, rd, w);
    op(1'b1, 12'h027, 32'hC0000003, rd, w);
    op(1'b0, 12'h027, '0, rd, w);
    check("R6 youngest forwarded", rd, 32'hC0000003);
    check("R6 forward no stall", 32'(w), 32'd0);
    op(1'b1, 12'h040, 32'hD0000004, rd, w);
    check("R2 fourth store no stall", 32'(w), 32'd0);
    probe(1'b1, 12'h041, 32'hE0000005, st);
    check("R2 full queue stalls", {31'd0, st}, 32'd1);
    ack_en = 1'b1;
    op(1'b1, 12'h041, 32'hE0000005, rd, w);
    drain();
    ack_en = 1'b0;
    op(1'b0, 12'h027, '0, rd, w);
    check("R7 forwarded word installed", rd, 32'hC0000003);
    check("R7 hit no stall", 32'(w), 32'd0);

    // Random mix over a small conflicting address pool.
    ack_en = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic          we;
      logic [DW-1:0] d;
      a  = AW'((($urandom % 4) << IW) | ($urandom % 4));
      we = ($urandom % 10) < 6;
      d  = $urandom;
      if (we) op(1'b1, a, d, rd, w);
      else begin
        op(1'b0, a, '0, rd, w);
        check("R6/R8/R10 random load", rd, ref_img[a]);
      end
    end
    drain();
    check("R5 all stores drained", 32'(n_seen), 32'(n_exp));
    for (int t = 0; t < 8; t++) begin
      for (int i = 0; i < (1 << IW); i++) begin
        check("R5 memory image", mem_img[(t << IW) | i], ref_img[(t << IW) | i]);
      end
    end
    finish_run();
  end
endmodule